// File: doc/BRIEF.md
# Prefetch Priority Scheduler

This block ranks a batch of candidate configuration prefetches and hands them, one at a time, to a bitstream transfer engine. Each candidate arrives with a tag and three attributes: the dynamic priority of its thread, the static probability that its branch executes, and a static preference among alternative implementations. The block evaluates a polynomial with programmable coefficients over these attributes. The resulting 16-bit score decides whether the candidate is discarded, loaded partially, or loaded in full. Kept candidates are inserted into a sorted queue, one per cycle. The queue keeps the highest score at its head. When two scores are equal, the earlier arrival stays ahead.

A batch ends when the candidate carrying the end-of-batch flag is accepted, or when the queue fills. The block then leaves its loading phase and issues transfer requests from the head of the queue. It keeps issuing until the queue is empty or a new scheduler command arrives. A scheduler command empties the queue and ends issue at once.

Both streams use valid/ready handshakes. A candidate is taken on a cycle where `cand_valid` and `cand_ready` are both high. A transfer request is consumed on a cycle where `xfer_valid` and `xfer_ready` are both high. While `xfer_valid` is high and `xfer_ready` is low, the request stays unchanged. The transfer engine may hold `xfer_ready` low for any length of time. The candidate source may hold `cand_valid` low for any length of time.

Top module: `prefetch_sched`

## Requirements
- R1: The score is c0 + c1*T + (c2*E)/256 + c3*I + (c4*T*E)/256, where T is the thread priority, E is the execution probability (8-bit, fraction of 256) and I is the implementation priority. Both divisions are integer divisions that truncate. The score is computed at full precision and then saturated to 65535. It appears on `xfer_prio`.
- R2: Kept candidates are issued in non-increasing order of score.
- R3: Candidates with equal scores are issued in the order they were accepted.
- R4: A candidate scoring below `thr_lo` is accepted but never issued. If a batch ends with no kept candidate, the block stays in the loading phase and `busy` stays low.
- R5: Thresholds and the chunk count are sampled when a candidate is accepted. If the score is at least `thr_hi` (and not below `thr_lo`), the request has `xfer_full`=1 and `xfer_chunks`=0. Otherwise the request has `xfer_full`=0 and `xfer_chunks` equal to `part_chunks`.
- R6: The queue holds up to 16 entries. When a kept candidate fills it, `cand_ready` drops and issue starts without an end-of-batch flag.
- R7: Accepting a candidate with `cand_last`=1 starts issue on the next cycle if the queue is not empty. `busy` is high during issue. `busy` drops on the cycle after the last entry is consumed.
- R8: While `sched_cmd` is high, `xfer_valid` and `cand_ready` are both low. From the next cycle on, the queue is empty, `busy` is low and no request is issued.
- R9: While `xfer_valid` is high and `xfer_ready` is low, the request fields stay stable into the next cycle, unless a scheduler command intervenes.
- R10: After reset, `busy`=0, `xfer_valid`=0 and `cand_ready`=1.
- R11: `cand_ready` is low whenever `busy` is high. Candidates are taken only in the loading phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef0 | input | 16 | Constant term |
| coef1 | input | 16 | Thread-priority weight |
| coef2 | input | 16 | Probability weight |
| coef3 | input | 16 | Implementation-priority weight |
| coef4 | input | 16 | Thread-by-probability weight |
| thr_lo | input | 16 | Scores below this are discarded |
| thr_hi | input | 16 | Scores at or above this get a full load |
| part_chunks | input | 6 | Chunk count for a partial load |
| cand_valid | input | 1 | Candidate present |
| cand_ready | output | 1 | Candidate can be taken |
| cand_tag | input | 6 | Candidate identifier |
| cand_thread | input | 8 | Thread priority |
| cand_prob | input | 8 | Execution probability |
| cand_impl | input | 8 | Implementation priority |
| cand_last | input | 1 | Final candidate of the batch |
| sched_cmd | input | 1 | New scheduler command: flush and stop |
| busy | output | 1 | Issue phase active |
| xfer_valid | output | 1 | Transfer request present |
| xfer_ready | input | 1 | Transfer engine takes the request |
| xfer_tag | output | 6 | Tag of the request |
| xfer_full | output | 1 | 1 = whole bitstream |
| xfer_chunks | output | 6 | Chunks for a partial load, 0 when full |
| xfer_prio | output | 16 | Score of the request |

## Verification
The bench targets the following corner cases, and what a faulty design would show for each:
- Runs of equal scores: a design that inserts before equals would issue the tied tags in reverse order.
- Scores that overflow 16 bits: a design that wraps instead of saturating would put a small value on `xfer_prio` and misclassify the candidate.
- A batch that fills the queue without an end flag: a design that relies only on the end flag would deadlock or overwrite an entry.
- A scheduler command in the middle of issue: a late flush would let one more request escape after the command.
- A batch in which every candidate is dropped: a careless phase change would raise `busy` with nothing to send.
- Long stalls on `xfer_ready`: these expose a head that moves while it is waiting.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    CLS_DROP = 2'd0,
    CLS_PART = 2'd1,
    CLS_FULL = 2'd2
  } pfs_cls_e;
endpackage

// File: rtl/pfs_poly.sv
module pfs_poly #(
  parameter int ATTR_W = 8,
  parameter int PRIO_W = 16
) (
  input  logic [PRIO_W-1:0] c0,
  input  logic [PRIO_W-1:0] c1,
  input  logic [PRIO_W-1:0] c2,
  input  logic [PRIO_W-1:0] c3,
  input  logic [PRIO_W-1:0] c4,
  input  logic [ATTR_W-1:0] thread_p,
  input  logic [ATTR_W-1:0] prob,
  input  logic [ATTR_W-1:0] impl_p,
  output logic [PRIO_W-1:0] score
);
  // wide enough for every term plus carries of a five-term sum
  localparam int PW = 2*ATTR_W + PRIO_W + 3;

  logic [PW-1:0] t0, t1, t2, t3, t4, sum;

  always_comb begin
    t0  = PW'(c0);
    t1  = PW'(c1) * PW'(thread_p);
    t2  = (PW'(c2) * PW'(prob)) >> ATTR_W;
    t3  = PW'(c3) * PW'(impl_p);
    t4  = (PW'(c4) * PW'(thread_p) * PW'(prob)) >> ATTR_W;
    sum = t0 + t1 + t2 + t3 + t4;
    if (|sum[PW-1:PRIO_W]) score = '1;
    else                   score = sum[PRIO_W-1:0];
  end
endmodule

// File: rtl/pfs_sortq.sv
module pfs_sortq #(
  parameter int DEPTH = 16,
  parameter int KEY_W = 16,
  parameter int PAY_W = 13,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ins,
  input  logic [KEY_W-1:0] ins_key,
  input  logic [PAY_W-1:0] ins_pay,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic [KEY_W-1:0] head_key,
  output logic [PAY_W-1:0] head_pay
);
  logic [KEY_W-1:0] key_q [DEPTH];
  logic [KEY_W-1:0] key_d [DEPTH];
  logic [KEY_W-1:0] key_up [DEPTH];
  logic [KEY_W-1:0] key_dn [DEPTH];
  logic [PAY_W-1:0] pay_q [DEPTH];
  logic [PAY_W-1:0] pay_d [DEPTH];
  logic [PAY_W-1:0] pay_up [DEPTH];
  logic [PAY_W-1:0] pay_dn [DEPTH];
  logic [DEPTH-1:0] ge;     // occupied slot that stays ahead of the newcomer
  logic [DEPTH-1:0] ge_up;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    // equal keys count as "ahead", so arrival order survives ties
    assign ge[g] = (CNT_W'(g) < count) && (key_q[g] >= ins_key);
    if (g == 0) begin : g_first
      assign key_up[g] = ins_key;
      assign pay_up[g] = ins_pay;
      assign ge_up[g]  = 1'b1;
    end else begin : g_rest
      assign key_up[g] = key_q[g-1];
      assign pay_up[g] = pay_q[g-1];
      assign ge_up[g]  = ge[g-1];
    end
    if (g == DEPTH - 1) begin : g_tail
      assign key_dn[g] = key_q[g];
      assign pay_dn[g] = pay_q[g];
    end else begin : g_body
      assign key_dn[g] = key_q[g+1];
      assign pay_dn[g] = pay_q[g+1];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      key_d[i] = key_q[i];
      pay_d[i] = pay_q[i];
      if (ins && !ge[i]) begin
        key_d[i] = ge_up[i] ? ins_key : key_up[i];
        pay_d[i] = ge_up[i] ? ins_pay : pay_up[i];
      end else if (pop && !ins) begin
        key_d[i] = key_dn[i];
        pay_d[i] = pay_dn[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        key_q[i] <= '0;
        pay_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        key_q[i] <= key_d[i];
        pay_q[i] <= pay_d[i];
      end
      if (flush)     count <= '0;
      else if (ins)  count <= count + 1'b1;
      else if (pop)  count <= count - 1'b1;
    end
  end

  assign head_key = key_q[0];
  assign head_pay = pay_q[0];
endmodule

// File: rtl/prefetch_sched.sv
module prefetch_sched #(
  parameter int DEPTH   = 16,
  parameter int TAG_W   = 6,
  parameter int ATTR_W  = 8,
  parameter int PRIO_W  = 16,
  parameter int CHUNK_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRIO_W-1:0]  coef0,
  input  logic [PRIO_W-1:0]  coef1,
  input  logic [PRIO_W-1:0]  coef2,
  input  logic [PRIO_W-1:0]  coef3,
  input  logic [PRIO_W-1:0]  coef4,
  input  logic [PRIO_W-1:0]  thr_lo,
  input  logic [PRIO_W-1:0]  thr_hi,
  input  logic [CHUNK_W-1:0] part_chunks,
  input  logic               cand_valid,
  output logic               cand_ready,
  input  logic [TAG_W-1:0]   cand_tag,
  input  logic [ATTR_W-1:0]  cand_thread,
  input  logic [ATTR_W-1:0]  cand_prob,
  input  logic [ATTR_W-1:0]  cand_impl,
  input  logic               cand_last,
  input  logic               sched_cmd,
  output logic               busy,
  output logic               xfer_valid,
  input  logic               xfer_ready,
  output logic [TAG_W-1:0]   xfer_tag,
  output logic               xfer_full,
  output logic [CHUNK_W-1:0] xfer_chunks,
  output logic [PRIO_W-1:0]  xfer_prio
);
  import pfs_pkg::*;

  localparam int PAY_W = TAG_W + 1 + CHUNK_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              issuing;
  logic [CNT_W-1:0]  count, count_after;
  logic [PRIO_W-1:0] score;
  logic [PAY_W-1:0]  ins_pay, head_pay;
  pfs_cls_e          cls;
  logic              accept, ins, pop;

  pfs_poly #(.ATTR_W(ATTR_W), .PRIO_W(PRIO_W)) u_poly (
    .c0(coef0), .c1(coef1), .c2(coef2), .c3(coef3), .c4(coef4),
    .thread_p(cand_thread), .prob(cand_prob), .impl_p(cand_impl),
    .score(score)
  );

  always_comb begin
    if (score < thr_lo)       cls = CLS_DROP;
    else if (score >= thr_hi) cls = CLS_FULL;
    else                      cls = CLS_PART;
  end

  assign cand_ready = !issuing && (count < CNT_W'(DEPTH)) && !sched_cmd;
  assign accept     = cand_valid && cand_ready;
  assign ins        = accept && (cls != CLS_DROP);
  assign xfer_valid = issuing && (count != '0) && !sched_cmd;
  assign pop        = xfer_valid && xfer_ready;
  assign ins_pay    = (cls == CLS_FULL) ? {cand_tag, 1'b1, {CHUNK_W{1'b0}}}
                                        : {cand_tag, 1'b0, part_chunks};
  assign count_after = count + CNT_W'(ins);

  pfs_sortq #(.DEPTH(DEPTH), .KEY_W(PRIO_W), .PAY_W(PAY_W)) u_sortq (
    .clk(clk), .rst_n(rst_n), .flush(sched_cmd),
    .ins(ins), .ins_key(score), .ins_pay(ins_pay), .pop(pop),
    .count(count), .head_key(xfer_prio), .head_pay(head_pay)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issuing <= 1'b0;
    end else if (sched_cmd) begin
      issuing <= 1'b0;
    end else if (accept && (cand_last || count_after == CNT_W'(DEPTH))
                 && count_after != '0) begin
      issuing <= 1'b1;
    end else if (pop && count == CNT_W'(1)) begin
      issuing <= 1'b0;
    end
  end

  assign busy        = issuing;
  assign xfer_tag    = head_pay[PAY_W-1 -: TAG_W];
  assign xfer_full   = head_pay[CHUNK_W];
  assign xfer_chunks = head_pay[CHUNK_W-1:0];
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker #(
  parameter int TAG_W   = 6,
  parameter int PRIO_W  = 16,
  parameter int CHUNK_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sched_cmd,
  input logic               busy,
  input logic               cand_ready,
  input logic               xfer_valid,
  input logic               xfer_ready,
  input logic [TAG_W-1:0]   xfer_tag,
  input logic               xfer_full,
  input logic [CHUNK_W-1:0] xfer_chunks,
  input logic [PRIO_W-1:0]  xfer_prio
);
  logic [PRIO_W-1:0] last_prio;
  logic              have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_prio <= '0;
      have_prev <= 1'b0;
    end else if (sched_cmd || !busy) begin
      have_prev <= 1'b0;
    end else if (xfer_valid && xfer_ready) begin
      last_prio <= xfer_prio;
      have_prev <= 1'b1;
    end
  end

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (have_prev && xfer_valid) |-> (xfer_prio <= last_prio));

  p_full_chunks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_full) |-> (xfer_chunks == '0));

  p_valid_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> busy);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sched_cmd |=> (!busy && !xfer_valid));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (sched_cmd ||
      (xfer_valid && $stable(xfer_tag) && $stable(xfer_prio) &&
       $stable(xfer_full) && $stable(xfer_chunks))));

  p_no_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cand_ready);
endmodule

bind prefetch_sched pfs_checker #(
  .TAG_W(TAG_W), .PRIO_W(PRIO_W), .CHUNK_W(CHUNK_W)
) u_pfs_chk (
  .clk(clk), .rst_n(rst_n), .sched_cmd(sched_cmd), .busy(busy),
  .cand_ready(cand_ready), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
  .xfer_tag(xfer_tag), .xfer_full(xfer_full), .xfer_chunks(xfer_chunks),
  .xfer_prio(xfer_prio)
);

// File: tb/test_prefetch_sched.sv
`timescale 1ns/1ps
module test_prefetch_sched;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] coef0 = 0, coef1 = 0, coef2 = 0, coef3 = 0, coef4 = 0;
  logic [15:0] thr_lo = 0, thr_hi = 0;
  logic [5:0]  part_chunks = 0;
  logic        cand_valid = 0, cand_last = 0, sched_cmd = 0, xfer_ready = 0;
  logic [5:0]  cand_tag = 0;
  logic [7:0]  cand_thread = 0, cand_prob = 0, cand_impl = 0;
  logic        cand_ready, busy, xfer_valid, xfer_full;
  logic [5:0]  xfer_tag, xfer_chunks;
  logic [15:0] xfer_prio;

  prefetch_sched i_prefetch_sched (
    .clk(clk), .rst_n(rst_n),
    .coef0(coef0), .coef1(coef1), .coef2(coef2), .coef3(coef3), .coef4(coef4),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .part_chunks(part_chunks),
    .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_tag(cand_tag),
    .cand_thread(cand_thread), .cand_prob(cand_prob), .cand_impl(cand_impl),
    .cand_last(cand_last), .sched_cmd(sched_cmd), .busy(busy),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_tag(xfer_tag),
    .xfer_full(xfer_full), .xfer_chunks(xfer_chunks), .xfer_prio(xfer_prio)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int rdy_mode = 1;       // 0: low, 1: high, 2: random
  int issued_after_cmd = 0;
  int cycles = 0;

  // behavioural reference state
  int m_prio[$], m_tag[$], m_full[$], m_chk[$];
  bit m_iss = 0;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int score(int t, int e, int i);
    longint s;
    s = longint'(coef0) + longint'(coef1) * t + ((longint'(coef2) * e) >> 8)
      + longint'(coef3) * i + ((longint'(coef4) * t * e) >> 8);
    return (s > 65535) ? 65535 : int'(s);
  endfunction

  always @(negedge clk) begin
    if (xfer_ready === 1'b0 || xfer_ready === 1'b1 || 1) begin
      case (rdy_mode)
        0: xfer_ready <= 1'b0;
        1: xfer_ready <= 1'b1;
        default: xfer_ready <= 1'($urandom_range(0, 1));
      endcase
    end
  end

  // reference model compared every cycle, away from the clock edge
  always begin
    @(negedge clk);
    #2;
    cycles++;
    if (!rst_n) begin
      m_prio.delete(); m_tag.delete(); m_full.delete(); m_chk.delete();
      m_iss = 0;
    end else begin
      bit e_rdy, e_val, acc, pop;
      int p, pos;
      e_rdy = !m_iss && m_prio.size() < DEPTH && !sched_cmd;
      e_val = m_iss && m_prio.size() > 0 && !sched_cmd;
      check("R11 cand_ready", cand_ready, e_rdy);
      check("R8 R7 xfer_valid", xfer_valid, e_val);
      check("R7 busy", busy, m_iss);
      if (e_val) begin
        check("R2 R3 xfer_tag order", xfer_tag, m_tag[0]);
        check("R1 xfer_prio", xfer_prio, m_prio[0]);
        check("R5 xfer_full", xfer_full, m_full[0]);
        check("R5 xfer_chunks", xfer_chunks, m_chk[0]);
      end
      acc = cand_valid && e_rdy;
      pop = e_val && xfer_ready;
      if (sched_cmd) begin
        m_prio.delete(); m_tag.delete(); m_full.delete(); m_chk.delete();
        m_iss = 0;
      end else if (acc) begin
        p = score(cand_thread, cand_prob, cand_impl);
        if (p >= thr_lo) begin
          pos = 0;
          while (pos < m_prio.size() && m_prio[pos] >= p) pos++;
          m_prio.insert(pos, p);
          m_tag.insert(pos, cand_tag);
          m_full.insert(pos, (p >= thr_hi) ? 1 : 0);
          m_chk.insert(pos, (p >= thr_hi) ? 0 : part_chunks);
        end
        if ((cand_last || m_prio.size() == DEPTH) && m_prio.size() > 0) m_iss = 1;
      end else if (pop) begin
        void'(m_prio.pop_front()); void'(m_tag.pop_front());
        void'(m_full.pop_front()); void'(m_chk.pop_front());
        if (m_prio.size() == 0) m_iss = 0;
      end
    end
  end

  task automatic send(input int tag, input int t, input int e, input int i,
                      input bit last);
    @(negedge clk);
    cand_valid = 1; cand_tag = 6'(tag); cand_thread = 8'(t);
    cand_prob = 8'(e); cand_impl = 8'(i); cand_last = last;
    forever begin
      #1;
      if (cand_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    cand_valid = 0; cand_last = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk); #3;
      if (!busy) break;
    end
  endtask

  task automatic pulse_cmd();
    @(negedge clk); sched_cmd = 1;
    @(negedge clk); sched_cmd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check("R10 busy after reset", busy, 0);
    check("R10 xfer_valid after reset", xfer_valid, 0);
    check("R10 cand_ready after reset", cand_ready, 1);
    @(negedge clk); rst_n = 1;

    coef0 = 10; coef1 = 4; coef2 = 64; coef3 = 2; coef4 = 8;
    thr_lo = 40; thr_hi = 300; part_chunks = 5;

    // distinct scores, mixed classes
    rdy_mode = 1;
    send(1, 10, 128, 5, 0);
    send(2, 60, 255, 1, 0);
    send(3, 1, 0, 0, 0);      // score 14 -> dropped (R4)
    send(4, 30, 200, 9, 0);
    send(5, 5, 10, 3, 1);
    wait_idle();

    // ties keep arrival order (R3)
    rdy_mode = 2;
    send(20, 20, 100, 4, 0);
    send(21, 20, 100, 4, 0);
    send(22, 90, 250, 4, 0);
    send(23, 20, 100, 4, 0);
    send(24, 20, 100, 4, 1);
    wait_idle();

    // saturation (R1)
    coef0 = 16'hFFF0; coef1 = 16'hFFFF;
    rdy_mode = 0;
    send(30, 200, 200, 200, 1);
    @(negedge clk); #3;
    check("R1 saturated score", xfer_prio, 65535);
    check("R5 saturated is full", xfer_full, 1);
    rdy_mode = 1;
    wait_idle();
    coef0 = 10; coef1 = 4;

    // fill without end flag (R6)
    rdy_mode = 0;
    for (int k = 0; k < DEPTH; k++) send(40 + (k % 20), k * 3, 128, k % 4, 0);
    @(negedge clk); #3;
    check("R6 cand_ready low when full", cand_ready, 0);
    check("R6 busy when full", busy, 1);
    rdy_mode = 2;
    wait_idle();

    // flush mid-issue (R8)
    rdy_mode = 1;
    for (int k = 0; k < 8; k++) send(k, 40 + k, 200, 2, k == 7);
    repeat (2) @(negedge clk);
    pulse_cmd();
    issued_after_cmd = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); #3;
      if (xfer_valid) issued_after_cmd++;
    end
    check("R8 no request after command", issued_after_cmd, 0);
    check("R8 busy cleared", busy, 0);

    // batch of dropped candidates only (R4)
    thr_lo = 16'hF000;
    send(50, 1, 1, 1, 0);
    send(51, 2, 2, 2, 1);
    repeat (3) @(negedge clk); #3;
    check("R4 all dropped stays idle", busy, 0);
    check("R4 all dropped no request", xfer_valid, 0);
    thr_lo = 40;

    // random batches with stalls and occasional commands
    for (int b = 0; b < 25; b++) begin
      int n;
      rdy_mode = 2;
      thr_lo = 16'($urandom_range(0, 200));
      thr_hi = 16'($urandom_range(150, 1200));
      part_chunks = 6'($urandom_range(1, 63));
      n = $urandom_range(1, DEPTH);
      for (int k = 0; k < n; k++)
        send(k + b, $urandom_range(0, 60), $urandom_range(0, 255),
             $urandom_range(0, 15), k == n - 1);
      if (b % 5 == 3) begin
        repeat (2) @(negedge clk);
        pulse_cmd();
      end
      wait_idle();
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule